// File: doc/BRIEF.md
# Fractional Cell Rate Pacer

The pacer hands out transmit opportunities for two ATM ports so that neither port ever runs faster than its peak cell rate. Software sets a global clock-step value and a target cell rate for each port through a small write port. For every rate write, the block divides the step-scaled clock frequency by the rate and gets a slot interval in units of 1/64 clock cycle. It splits that interval into an integer cycle count and a 6-bit fraction.

Each port has a pacing engine. It raises a one-cycle slot pulse, waits the integer number of cycles, and then pulses again. A 6-bit fraction accumulator inserts one extra cycle whenever it wraps. Over 64 slots the total time is therefore exactly 64 times the integer part plus the fraction. A per-port enable gates the engine. Dropping the enable returns the engine to phase zero.

Top module: `cell_rate_pacer`

## Requirements
- R1: After reset, no slot pulses are produced, busy is low, both ports are unprogrammed, and the effective clock step is 1.
- R2: A write with cfg_addr_i[1]=0 loads the clock step from cfg_data_i[3:0]. Value 0 is used as 1, value 3 is used as 2, values above 4 are used as 4, and 1, 2 and 4 are used as written.
- R3: The raw interval equals floor(floor(CLK_HZ × step / 2) / rate), counted in 1/64-cycle units.
- R4: The integer part is the raw interval shifted right by 6. The fraction is the low 6 bits of the raw interval plus one. When that sum reaches 64, the fraction becomes 0 and the integer part increases by one.
- R5: When the integer part from R4 is zero, both the integer part and the fraction are set to 1.
- R6: Let the integer part be I and the fraction be F. The gap from slot k to slot k+1 (k ≥ 1) is I cycles, plus one when k×F crosses a multiple of 64, that is, floor(k·F/64) − floor((k−1)·F/64).
- R7: A non-zero rate write raises busy for exactly CLK_HZ-derived ⌈log2(2·CLK_HZ+1)⌉ cycles. During that time the addressed port emits no slots. The addressed port then restarts at phase zero, and its first slot appears in the second cycle after busy falls.
- R8: A write of rate 0 leaves the addressed port unprogrammed. That port emits no slots and busy stays low.
- R9: While port_en_i[p] is low, port p emits no slots and its phase is reset. Its first slot after the enable rises comes in the next cycle, and the slots after it follow R6.
- R10: Configuration writes made while busy is high are ignored. Neither the clock step nor any rate changes.
- R11: A write with cfg_addr_i[1]=1 loads the rate of port cfg_addr_i[0]. The other port's slot output is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one pacing tick |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Bit 1: 0 = clock step, 1 = rate; bit 0: port index for rate |
| cfg_data_i | input | RATE_W | Write data (step in bits 3:0, or cell rate) |
| port_en_i | input | 2 | Per-port pacing enable |
| slot_o | output | 2 | Per-port one-cycle transmit-opportunity pulse |
| busy_o | output | 1 | High while an interval is being computed |

## Verification
A wrong quotient or a rounding error shows up at the slot output within the first two pulses after busy falls. It appears as a gap that is too long or too short. A fault in the fraction accumulator shows up as an extra cycle that lands in the wrong gap, at the latest within 64 slots. A stale phase after a rate write or an enable change moves the first pulse away from the cycle that R7 and R9 fix. Every configuration is therefore compared cycle by cycle against an arithmetic model over a window of 200 cycles.

// File: rtl/pacer_pkg.sv
// Shared constants and helpers for the cell rate pacer.
// Assumes a two-port configuration and a 6-bit interval fraction.
package pacer_pkg;
    localparam int NUM_PORTS = 2;
    localparam int FRAC_W    = 6;

    // Map a raw step field onto the legal set {1, 2, 4}.
    function automatic logic [2:0] clamp_step(input logic [3:0] raw);
        logic [2:0] s;
        if (raw == 4'd0)      s = 3'd1;
        else if (raw == 4'd3) s = 3'd2;
        else if (raw > 4'd4)  s = 3'd4;
        else                  s = raw[2:0];
        return s;
    endfunction
endpackage

// File: rtl/pacer_div.sv
// Restoring divider: one quotient bit per cycle, MSB first.
// Assumes start_i is raised only when busy_o is low, and that the divisor is non-zero.
// done_o is high in the final busy cycle; quot_o is valid only in that cycle.
module pacer_div #(
    parameter int DVD_W = 16,
    parameter int DVS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DVD_W-1:0] quot_o
);
    localparam int SW = (DVD_W > 1) ? $clog2(DVD_W) : 1;

    logic             running_q;
    logic [SW-1:0]    step_q;
    logic [DVD_W-1:0] dvd_q;
    logic [DVD_W-1:0] quot_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W:0]   trial;
    logic             ge;
    logic [DVS_W-1:0] rem_n;
    logic [DVD_W-1:0] quot_n;

    // Trial subtraction for the current bit.
    always_comb begin
        trial  = {rem_q, dvd_q[DVD_W-1]};
        ge     = (trial >= {1'b0, dvs_q});
        rem_n  = ge ? DVS_W'(trial - {1'b0, dvs_q}) : trial[DVS_W-1:0];
        quot_n = {quot_q[DVD_W-2:0], ge};
    end

    assign busy_o = running_q;
    assign done_o = running_q && (step_q == SW'(DVD_W - 1));
    assign quot_o = quot_n;

    // Step sequencing and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            step_q    <= '0;
            dvd_q     <= '0;
            quot_q    <= '0;
            rem_q     <= '0;
            dvs_q     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            step_q    <= '0;
            dvd_q     <= dividend_i;
            quot_q    <= '0;
            rem_q     <= '0;
            dvs_q     <= divisor_i;
        end else if (running_q) begin
            dvd_q  <= dvd_q << 1;
            rem_q  <= rem_n;
            quot_q <= quot_n;
            step_q <= step_q + 1'b1;
            if (done_o) running_q <= 1'b0;
        end
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !done_o) |=> running_q);
endmodule

// File: rtl/pacer_slot.sv
// Per-port slot engine: pulses once, then waits the integer interval plus an
// extra cycle whenever the 6-bit fraction accumulator wraps.
// Assumes ip_i >= 1 whenever load_i is high.
module pacer_slot #(
    parameter int IP_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            clear_i,
    input  logic            load_i,
    input  logic [IP_W-1:0] ip_i,
    input  logic [5:0]      fr_i,
    output logic            slot_o
);
    localparam int CW = IP_W + 1;

    logic            valid_q;
    logic [IP_W-1:0] ip_q;
    logic [5:0]      fr_q;
    logic [5:0]      acc_q;
    logic [CW-1:0]   cnt_q;
    logic [6:0]      acc_sum;

    // Fraction accumulation; bit 6 marks the extra cycle.
    assign acc_sum = {1'b0, acc_q} + {1'b0, fr_q};

    // Interval state, phase and slot pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ip_q    <= '0;
            fr_q    <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
            slot_o  <= 1'b0;
        end else if (clear_i) begin
            valid_q <= 1'b0;
            acc_q   <= '0;
            cnt_q   <= '0;
            slot_o  <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            ip_q    <= ip_i;
            fr_q    <= fr_i;
            acc_q   <= '0;
            cnt_q   <= '0;
            slot_o  <= 1'b0;
        end else if (!en_i || !valid_q) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            slot_o <= 1'b0;
        end else if (cnt_q == '0) begin
            slot_o <= 1'b1;
            acc_q  <= acc_sum[5:0];
            cnt_q  <= CW'(ip_q) + CW'(acc_sum[6]) - CW'(1);
        end else begin
            slot_o <= 1'b0;
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    // R6
    slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o && ip_q > IP_W'(1)) |=> !slot_o);
    // R9
    slot_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !slot_o);
endmodule

// File: rtl/cell_rate_pacer.sv
// Top of the pacer: configuration registers, interval computation with
// fraction rounding, and one slot engine per port.
// Assumes a pacing tick of one clock cycle running at CLK_HZ.
module cell_rate_pacer #(
    parameter int CLK_HZ = 20000,
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [RATE_W-1:0] cfg_data_i,
    input  logic [1:0]        port_en_i,
    output logic [1:0]        slot_o,
    output logic              busy_o
);
    import pacer_pkg::*;

    localparam int DVD_W = $clog2(2 * CLK_HZ + 1);
    localparam int IP_W  = DVD_W - FRAC_W + 1;
    localparam logic [DVD_W-1:0] DVD_S1 = DVD_W'(CLK_HZ / 2);
    localparam logic [DVD_W-1:0] DVD_S2 = DVD_W'(CLK_HZ);
    localparam logic [DVD_W-1:0] DVD_S4 = DVD_W'(CLK_HZ * 2);

    logic [2:0]       step_q;
    logic             tgt_q;
    logic             wr_ok;
    logic             step_wr;
    logic             rate_wr;
    logic             div_start;
    logic             div_done;
    logic [DVD_W-1:0] dividend;
    logic [DVD_W-1:0] quot;
    logic [IP_W-1:0]  ip_rnd;
    logic [5:0]       fr_rnd;
    logic [6:0]       fr_inc;

    assign wr_ok     = cfg_we_i && !busy_o;
    assign step_wr   = wr_ok && !cfg_addr_i[1];
    assign rate_wr   = wr_ok && cfg_addr_i[1];
    assign div_start = rate_wr && (cfg_data_i != '0);

    // Step-scaled clock: CLK_HZ * step / 2.
    always_comb begin
        case (step_q)
            3'd2:    dividend = DVD_S2;
            3'd4:    dividend = DVD_S4;
            default: dividend = DVD_S1;
        endcase
    end

    // Step register and target port of the running division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 3'd1;
            tgt_q  <= 1'b0;
        end else begin
            if (step_wr)   step_q <= clamp_step(cfg_data_i[3:0]);
            if (div_start) tgt_q  <= cfg_addr_i[0];
        end
    end

    pacer_div #(.DVD_W(DVD_W), .DVS_W(RATE_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (dividend),
        .divisor_i  (cfg_data_i),
        .busy_o     (busy_o),
        .done_o     (div_done),
        .quot_o     (quot)
    );

    // Split quotient into integer and fraction, with carry and zero clamp.
    always_comb begin
        ip_rnd = IP_W'(quot[DVD_W-1:FRAC_W]);
        fr_inc = {1'b0, quot[FRAC_W-1:0]} + 7'd1;
        fr_rnd = fr_inc[5:0];
        if (fr_inc[6]) ip_rnd = ip_rnd + IP_W'(1);
        if (ip_rnd == '0) begin
            ip_rnd = IP_W'(1);
            fr_rnd = 6'd1;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pacer_slot #(.IP_W(IP_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (port_en_i[p]),
            .clear_i (rate_wr && (cfg_addr_i[0] == 1'(p))),
            .load_i  (div_done && (tgt_q == 1'(p))),
            .ip_i    (ip_rnd),
            .fr_i    (fr_rnd),
            .slot_o  (slot_o[p])
        );
    end

    // R5
    ip_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (ip_rnd != '0));
    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cfg_we_i) |=> $stable(step_q));
    // R2
    step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_q) == 1 && step_q != 3'd0);
endmodule

// File: tb/cell_rate_pacer_bench.sv
module cell_rate_pacer_bench;
    localparam int CLK_HZ   = 20000;
    localparam int RATE_W   = 12;
    localparam int BUSY_CYC = $clog2(2 * CLK_HZ + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [RATE_W-1:0] cfg_data = '0;
    logic [1:0]        port_en = '0;
    logic [1:0]        slot;
    logic              busy;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cell_rate_pacer #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W)) u_cell_rate_pacer (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_data_i(cfg_data), .port_en_i(port_en), .slot_o(slot), .busy_o(busy)
    );

    function automatic void exp_interval(input int ts, input int rate,
                                         output int ip, output int fr);
        int tsc, raw;
        tsc = (ts < 1) ? 1 : (ts > 4) ? 4 : (ts == 3) ? 2 : ts;
        raw = ((CLK_HZ * tsc) / 2) / rate;
        ip = raw >> 6;
        fr = (raw & 63) + 1;
        if (fr == 64) begin fr = 0; ip++; end
        if (ip == 0) begin ip = 1; fr = 1; end
    endfunction

    function automatic int rate_of(input int i);
        case (i)
            0: return 630;  1: return 10000; 2: return 200;  3: return 300;
            4: return 97;   5: return 625;   6: return 4095; 7: return 1;
            default: return 1234;
        endcase
    endfunction

    task automatic cfg_write(input logic [1:0] a, input int d);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = RATE_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Starting at a phase-zero point, compare the slot stream against the model.
    task automatic compare_pattern(input int port, input int ip, input int fr,
                                   input int window, input string tag);
        int next_t = 1, acc = 0, bad = 0, got = 0, want = 0, at = 0;
        for (int t = 1; t <= window; t++) begin
            @(negedge clk);
            want = (t == next_t) ? 1 : 0;
            if (want == 1) begin
                acc += fr;
                next_t += ip + ((acc >= 64) ? 1 : 0);
                acc = acc % 64;
            end
            if ((int'(slot[port]) != want || slot[1-port] != 1'b0) && !bad) begin
                bad = 1; got = int'(slot[port]); at = t;
            end
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: port %0d cycle %0d slot=%0d expected=%0d (ip=%0d fr=%0d)",
                     tag, port, at, got, 1 - got, ip, fr);
        end
    endtask

    // Count busy cycles following a rate write, then check the pulse pattern.
    task automatic program_and_check(input int port, input bit wr_ts, input int ts,
                                     input int rate, input int ip, input int fr,
                                     input string tag);
        int n = 0;
        port_en = 2'(1 << port);
        if (wr_ts) cfg_write(2'b00, ts);
        cfg_write({1'b1, 1'(port)}, rate);
        while (busy) begin n++; @(negedge clk); end
        checks++;
        if (n != BUSY_CYC) begin
            errors++;
            $display("FAIL R7: busy cycles actual=%0d expected=%0d", n, BUSY_CYC);
        end
        compare_pattern(port, ip, fr, 200, tag);
    endtask

    initial begin
        #(150000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int ip, fr, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (slot != 2'b00 || busy != 1'b0) begin
            errors++;
            $display("FAIL R1: slot=%b busy=%b expected slot=00 busy=0", slot, busy);
        end
        // R1: default step is 1 (rate 97 -> raw 103 -> ip 1, fr 40)
        exp_interval(1, 97, ip, fr);
        program_and_check(0, 1'b0, 0, 97, ip, fr, "R1 default step");

        // R2 R3 R4 R5 R6 R7 R11: sweep of step codes, ports and rates
        for (int ts = 0; ts < 8; ts++)
            for (int p = 0; p < 2; p++)
                for (int ri = 0; ri < 9; ri++) begin
                    exp_interval(ts, rate_of(ri), ip, fr);
                    program_and_check(p, 1'b1, ts, rate_of(ri), ip, fr,
                                      "R2/R3/R4/R5/R6/R11 sweep");
                end

        // R4: carry case raw=63 -> every-cycle pulses
        exp_interval(4, 630, ip, fr);
        checks++;
        if (ip != 1 || fr != 0) begin
            errors++;
            $display("FAIL R4: model ip=%0d fr=%0d expected ip=1 fr=0", ip, fr);
        end
        program_and_check(0, 1'b1, 4, 630, ip, fr, "R4 carry");

        // R10: writes during busy are ignored
        port_en = 2'b01;
        cfg_write(2'b00, 4);
        cfg_write(2'b10, 630);
        cfg_write(2'b10, 4095);
        cfg_write(2'b00, 1);
        while (busy) @(negedge clk);
        exp_interval(4, 630, ip, fr);
        compare_pattern(0, ip, fr, 100, "R10 rate kept");
        exp_interval(4, 200, ip, fr);
        program_and_check(0, 1'b0, 0, 200, ip, fr, "R10 step kept");

        // R9: enable low silences the port and restarts its phase
        port_en = 2'b00;
        n = 0;
        for (int t = 0; t < 7; t++) begin
            @(negedge clk);
            if (slot != 2'b00) n++;
        end
        checks++;
        if (n != 0) begin
            errors++;
            $display("FAIL R9: pulses while disabled actual=%0d expected=0", n);
        end
        port_en = 2'b01;
        compare_pattern(0, ip, fr, 100, "R9 restart");

        // R8: zero rate leaves port unprogrammed, no busy
        cfg_write(2'b10, 0);
        n = 0;
        for (int t = 0; t < 100; t++) begin
            if (slot != 2'b00 || busy) n++;
            @(negedge clk);
        end
        checks++;
        if (n != 0) begin
            errors++;
            $display("FAIL R8: active cycles actual=%0d expected=0", n);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule